// File: doc/BRIEF.md
# UART Interrupt Identifier

This block turns the status sources of a 16550-style serial port into a single prioritised interrupt code and one interrupt request line. The sources are receiver line errors, the receive character timeout, received data (with a FIFO threshold when the FIFOs are on), transmit holding empty, and modem-status changes. Each source counts only while its own bit in the 4-bit interrupt enable value is set. The identifier byte also shows whether the FIFOs are enabled.

The block also keeps the transmit-empty pending flag. This flag follows software events: a write to the transmit holding register clears it, and a read of the identifier that reports transmit-empty also clears it. A change of the transmit-empty enable bit recomputes it. A rising holding-empty status sets it. The FIFOs, the serializer and the baud timing are outside the block and feed it through plain status inputs.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is high, and on the first cycle after it, the identifier reads 0x01 and the interrupt line is low, whatever the inputs are.
- R2: Sources rank from highest to lowest as follows. Line error has code 0x6. Character timeout has code 0xC. Received data has code 0x4. Transmit empty has code 0x2. Modem change has code 0x0. When nothing qualifies, the code is 0x1. The highest qualifying source sets identifier bits 3:0.
- R3: The line-error source qualifies when enable bit 2 is set and at least one of the four error inputs (overrun, parity, framing, break) is high.
- R4: The character timeout qualifies only when enable bit 0 (the received-data enable) is set. No separate enable bit exists for it.
- R5: With the FIFOs enabled, received data qualifies when data-ready is high and the FIFO count is at least the trigger level. With the FIFOs disabled, data-ready and enable bit 0 are enough. Modem change qualifies when enable bit 3 is set and any delta input is high.
- R6: Identifier bits 7:6 read 11 while the FIFO-enable input is high and 00 otherwise. Bits 5:4 always read 0.
- R7: The interrupt line is high exactly when identifier bits 3:0 differ from 0x1.
- R8: A read strobe of the identifier, issued while bits 3:0 show 0x2, clears the transmit-empty pending flag.
- R9: A write strobe of the transmit holding register clears the transmit-empty pending flag.
- R10: When enable bit 1 changes value, the pending flag becomes 1 if the new bit and the holding-empty input are both 1. Otherwise it becomes 0.
- R11: A rising edge of the holding-empty input sets the pending flag. Transmit empty qualifies when enable bit 1 and the pending flag are both set.
- R12: A setting event in the same cycle as a clearing read or write wins, and the pending flag ends up set.
- R13: The identifier and the interrupt line are registered. They reflect the inputs and strobes of the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_en | input | 4 | Enable bits: 0 received data/timeout, 1 transmit empty, 2 line error, 3 modem change |
| line_err | input | 4 | Overrun, parity, framing and break error flags |
| rx_ready | input | 1 | Receive data ready |
| fifo_on | input | 1 | FIFOs enabled |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trigger | input | CNT_W | Receive FIFO trigger level |
| rx_timeout | input | 1 | Character timeout pending |
| tx_empty | input | 1 | Transmit holding register empty |
| modem_delta | input | 4 | Modem-status change flags |
| thr_write | input | 1 | Write strobe of the transmit holding register |
| iid_read | input | 1 | Read strobe of the identifier |
| iid | output | 8 | Interrupt identifier byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default count width of 5 bits. This lets the FIFO count reach a full 16-entry fill against a 14-entry trigger, and also the exact-equality threshold at 4. A table of input patterns exercises each source alone, masked and in competition, with the FIFOs both on and off. Directed sequences then drive the strobe and edge interplay of the transmit-empty pending flag, including the same-cycle set-versus-clear cases and the one-cycle output latency.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [3:0] {
        IID_MODEM = 4'h0,
        IID_NONE  = 4'h1,
        IID_TXE   = 4'h2,
        IID_RXD   = 4'h4,
        IID_LINE  = 4'h6,
        IID_TMO   = 4'hC
    } iid_code_e;

    localparam int NUM_SRC  = 5;
    localparam int EN_RXD   = 0;
    localparam int EN_TXE   = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    // Highest priority in the most significant position.
    typedef struct packed {
        logic line;
        logic tmo;
        logic rxd;
        logic txe;
        logic modem;
    } src_vec_t;

    function automatic iid_code_e code_of_bit(input int pos);
        case (pos)
            4:       return IID_LINE;
            3:       return IID_TMO;
            2:       return IID_RXD;
            1:       return IID_TXE;
            default: return IID_MODEM;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_txe_track.sv
module uart_irq_txe_track (
    input  logic clk,
    input  logic rst,
    input  logic txe_en,
    input  logic tx_empty,
    input  logic thr_write,
    input  logic iid_read,
    input  logic shown_txe,
    output logic pend_nxt
);
    logic en_q, tx_q, pend_q;
    logic en_chg, tx_rise, clr_evt;

    assign en_chg  = txe_en != en_q;
    assign tx_rise = tx_empty && !tx_q;
    assign clr_evt = thr_write || (iid_read && shown_txe);

    always_comb begin
        pend_nxt = pend_q;
        if (en_chg)       pend_nxt = txe_en && tx_empty;
        else if (tx_rise) pend_nxt = 1'b1;
        else if (clr_evt) pend_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            tx_q   <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            en_q   <= txe_en;
            tx_q   <= tx_empty;
            pend_q <= pend_nxt;
        end
    end

    p_rd_clear_r8: assert property (@(posedge clk) disable iff (rst)
        iid_read && shown_txe && !en_chg && !tx_rise |=> !pend_q);
    p_wr_clear_r9: assert property (@(posedge clk) disable iff (rst)
        thr_write && !en_chg && !tx_rise |=> !pend_q);
    p_rearm_r10: assert property (@(posedge clk) disable iff (rst)
        en_chg |=> pend_q == ($past(txe_en) && $past(tx_empty)));
    p_rise_set_r11: assert property (@(posedge clk) disable iff (rst)
        tx_rise && !en_chg |=> pend_q);
endmodule

// File: rtl/uart_irq_src.sv
module uart_irq_src
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [3:0]       irq_en,
    input  logic [3:0]       line_err,
    input  logic             rx_ready,
    input  logic             fifo_on,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trigger,
    input  logic             rx_timeout,
    input  logic             txe_pend,
    input  logic [3:0]       modem_delta,
    output src_vec_t         src
);
    logic at_level;
    assign at_level = !fifo_on || (rx_count >= rx_trigger);

    always_comb begin
        src.line  = irq_en[EN_LINE]  && (|line_err);
        src.tmo   = irq_en[EN_RXD]   && rx_timeout;
        src.rxd   = irq_en[EN_RXD]   && rx_ready && at_level;
        src.txe   = irq_en[EN_TXE]   && txe_pend;
        src.modem = irq_en[EN_MODEM] && (|modem_delta);
    end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t src,
    input  logic     fifo_on,
    output logic [7:0] iid_q,
    output logic     irq_q
);
    logic [NUM_SRC-1:0] bits;
    iid_code_e          code;

    assign bits = src;

    always_comb begin
        code = IID_NONE;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (bits[i]) code = code_of_bit(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            iid_q <= {4'h0, IID_NONE};
            irq_q <= 1'b0;
        end else begin
            iid_q <= {{2{fifo_on}}, 2'b00, code};
            irq_q <= code != IID_NONE;
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (iid_q == 8'h01) && !irq_q);
    p_line_top_r2: assert property (@(posedge clk) disable iff (rst)
        src.line |=> iid_q[3:0] == 4'h6);
    p_fifo_bits_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> iid_q[7:6] == {2{$past(fifo_on)}} && iid_q[5:4] == 2'b00);
    p_irq_code_r7: assert property (@(posedge clk) disable iff (rst)
        irq_q == (iid_q[3:0] != 4'h1));
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       irq_en,
    input  logic [3:0]       line_err,
    input  logic             rx_ready,
    input  logic             fifo_on,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trigger,
    input  logic             rx_timeout,
    input  logic             tx_empty,
    input  logic [3:0]       modem_delta,
    input  logic             thr_write,
    input  logic             iid_read,
    output logic [7:0]       iid,
    output logic             irq
);
    logic     pend_nxt;
    logic     shown_txe;
    src_vec_t src;

    assign shown_txe = iid[3:0] == IID_TXE;

    uart_irq_txe_track u_track (
        .clk       (clk),
        .rst       (rst),
        .txe_en    (irq_en[EN_TXE]),
        .tx_empty  (tx_empty),
        .thr_write (thr_write),
        .iid_read  (iid_read),
        .shown_txe (shown_txe),
        .pend_nxt  (pend_nxt)
    );

    uart_irq_src #(.CNT_W(CNT_W)) u_src (
        .irq_en      (irq_en),
        .line_err    (line_err),
        .rx_ready    (rx_ready),
        .fifo_on     (fifo_on),
        .rx_count    (rx_count),
        .rx_trigger  (rx_trigger),
        .rx_timeout  (rx_timeout),
        .txe_pend    (pend_nxt),
        .modem_delta (modem_delta),
        .src         (src)
    );

    uart_irq_prio u_prio (
        .clk     (clk),
        .rst     (rst),
        .src     (src),
        .fifo_on (fifo_on),
        .iid_q   (iid),
        .irq_q   (irq)
    );

    p_tmo_gate_r4: assert property (@(posedge clk) disable iff (rst)
        rx_timeout && irq_en[0] && !irq_en[2] |=> iid[3:0] == 4'hC);
endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
    localparam int CLK_P = 10;
    localparam int CNT_W = 5;

    typedef struct packed {
        logic [3:0] en;
        logic [3:0] err;
        logic       rdy;
        logic       fifo;
        logic [4:0] cnt;
        logic [4:0] trig;
        logic       tmo;
        logic [3:0] msr;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'hF, 4'h1, 1'b1, 1'b0, 5'd0,  5'd0,  1'b1, 4'h1, 8'h06}, // R2 R3 all sources
        '{4'h0, 4'hF, 1'b0, 1'b0, 5'd0,  5'd0,  1'b0, 4'h0, 8'h01}, // R3 masked
        '{4'h4, 4'h8, 1'b0, 1'b0, 5'd0,  5'd0,  1'b0, 4'h0, 8'h06}, // R3 break alone
        '{4'h4, 4'h0, 1'b1, 1'b0, 5'd0,  5'd0,  1'b0, 4'h0, 8'h01}, // R3 no error
        '{4'h1, 4'h0, 1'b1, 1'b1, 5'd1,  5'd4,  1'b1, 4'h0, 8'hCC}, // R4 timeout
        '{4'hE, 4'h0, 1'b0, 1'b1, 5'd0,  5'd0,  1'b1, 4'h0, 8'hC1}, // R4 gated by bit 0
        '{4'h1, 4'h0, 1'b1, 1'b1, 5'd3,  5'd4,  1'b0, 4'h0, 8'hC1}, // R5 below trigger
        '{4'h1, 4'h0, 1'b1, 1'b1, 5'd4,  5'd4,  1'b0, 4'h0, 8'hC4}, // R5 at trigger
        '{4'h1, 4'h0, 1'b0, 1'b1, 5'd4,  5'd4,  1'b0, 4'h0, 8'hC1}, // R5 needs ready
        '{4'h1, 4'h0, 1'b1, 1'b0, 5'd0,  5'd14, 1'b0, 4'h0, 8'h04}, // R5 R6 non-FIFO
        '{4'h1, 4'h0, 1'b1, 1'b1, 5'd16, 5'd14, 1'b0, 4'h0, 8'hC4}, // R5 full FIFO
        '{4'h8, 4'h0, 1'b0, 1'b0, 5'd0,  5'd0,  1'b0, 4'h4, 8'h00}, // R2 R7 modem
        '{4'h9, 4'h0, 1'b1, 1'b0, 5'd0,  5'd0,  1'b0, 4'h2, 8'h04}, // R2 data over modem
        '{4'h8, 4'h0, 1'b0, 1'b0, 5'd0,  5'd0,  1'b0, 4'h0, 8'h01}, // R5 no delta
        '{4'h5, 4'h2, 1'b0, 1'b0, 5'd0,  5'd0,  1'b1, 4'h0, 8'h06}  // R2 line over timeout
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [3:0]       irq_en = '0;
    logic [3:0]       line_err = '0;
    logic             rx_ready = 1'b0;
    logic             fifo_on = 1'b0;
    logic [CNT_W-1:0] rx_count = '0;
    logic [CNT_W-1:0] rx_trigger = '0;
    logic             rx_timeout = 1'b0;
    logic             tx_empty = 1'b0;
    logic [3:0]       modem_delta = '0;
    logic             thr_write = 1'b0;
    logic             iid_read = 1'b0;
    logic [7:0]       iid;
    logic             irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    uart_irq_ident #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .irq_en(irq_en), .line_err(line_err),
        .rx_ready(rx_ready), .fifo_on(fifo_on), .rx_count(rx_count),
        .rx_trigger(rx_trigger), .rx_timeout(rx_timeout), .tx_empty(tx_empty),
        .modem_delta(modem_delta), .thr_write(thr_write), .iid_read(iid_read),
        .iid(iid), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] exp_iid);
        logic exp_irq;
        exp_irq = exp_iid[3:0] != 4'h1;
        checks++;
        if (iid !== exp_iid || irq !== exp_irq) begin
            fails++;
            $display("FAIL %s: iid=%02h irq=%b expected iid=%02h irq=%b",
                     req, iid, irq, exp_iid, exp_irq);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R13: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: active inputs while in reset
        irq_en = 4'hF; line_err = 4'hF;
        repeat (3) step();
        chk("R1 in reset", 8'h01);
        irq_en = '0; line_err = '0;
        rst = 1'b0;
        chk("R1 first cycle after reset", 8'h01);
        step();
        chk("R1 idle", 8'h01);

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            irq_en = VECS[i].en;   line_err = VECS[i].err;
            rx_ready = VECS[i].rdy; fifo_on = VECS[i].fifo;
            rx_count = VECS[i].cnt; rx_trigger = VECS[i].trig;
            rx_timeout = VECS[i].tmo; modem_delta = VECS[i].msr;
            step();
            chk("table R2 R3 R4 R5 R6 R7", VECS[i].exp);
        end

        irq_en = '0; line_err = '0; rx_ready = 0; fifo_on = 0;
        rx_count = '0; rx_trigger = '0; rx_timeout = 0; modem_delta = '0;
        step();
        chk("R2 nothing pending", 8'h01);

        irq_en = 4'h2; step();
        chk("R10 enable with holding not empty", 8'h01);
        tx_empty = 1'b1; step();
        chk("R11 holding-empty rise", 8'h02);

        iid_read = 1'b1; step(); iid_read = 1'b0;
        chk("R8 read clears", 8'h01);
        step();
        chk("R8 stays cleared", 8'h01);

        irq_en = 4'h0; step();
        chk("R10 enable off", 8'h01);
        irq_en = 4'h2; step();
        chk("R10 re-arm on toggle", 8'h02);

        thr_write = 1'b1; step(); thr_write = 1'b0;
        chk("R9 holding write clears", 8'h01);

        tx_empty = 1'b0; step();
        chk("R11 holding busy", 8'h01);
        tx_empty = 1'b1; thr_write = 1'b1; step(); thr_write = 1'b0;
        chk("R12 rise beats write", 8'h02);

        tx_empty = 1'b0; step();
        chk("R11 pending held", 8'h02);
        tx_empty = 1'b1; iid_read = 1'b1; step(); iid_read = 1'b0;
        chk("R12 rise beats read", 8'h02);

        // R13: output changes only at the edge
        irq_en = 4'h6; line_err = 4'h1;
        #1;
        chk("R13 before edge", 8'h02);
        step();
        chk("R13 after edge R2 line over txe", 8'h06);

        irq_en = 4'h0; tx_empty = 1'b0; step(); step();
        irq_en = 4'h2; step();
        chk("R10 toggle with holding busy", 8'h01);

        irq_en = 4'hF; line_err = 4'hF; rst = 1'b1; step();
        chk("R1 reset mid-run", 8'h01);
        rst = 1'b0; irq_en = '0; line_err = '0; step();
        chk("R1 after reset", 8'h01);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule